// File: doc/BRIEF.md
# Half-Rate Modulo 2^32-1 Adder

This block adds two unsigned words modulo 2^W-1 (W = 32 by default) with end-around carry, using a single (W+1)-bit adder that has a carry input. The adder is shared across two clock cycles to save area, so the block produces one result every other cycle.

A phase register drives the carry input of the adder and toggles on every clock edge. In the accept phase the adder forms A+B+1. If that sum carries out of the top bit, its low W bits are already the answer, and the valid strobe rises in that same cycle. Otherwise the carry-out is registered. In the following cycle the carry input is 0, the adder forms A+B, and the low W bits of that sum are the answer.

The caller presents a new operand pair in a cycle where `accept_out` is high. It keeps the pair unchanged through the next cycle, and takes `sum_out` in whichever of the two cycles has `valid_out` high. Zero has two forms: an exact multiple of 2^W-1 that is not zero can come out as all ones.

Top module: `modadd_half`

## Requirements
- R1: A synchronous active-high reset puts the block in the accept phase: in the cycle after any clock edge that sees `rst` high, `accept_out` is 1 and the registered carry-out is clear. If A+B < 2^W-1 in the first window after reset, `valid_out` is 0 in its first cycle and 1 in its second.
- R2: Outside reset, `accept_out` alternates 1, 0, 1, 0 on successive clock cycles. A window is an accept cycle followed by the non-accept cycle after it.
- R3: `valid_out` is high in exactly one cycle of every window.
- R4: When A+B >= 2^W-1, `valid_out` is high in the accept cycle and `sum_out` there equals A+B-(2^W-1).
- R5: When A+B < 2^W-1, `valid_out` is high in the second cycle of the window and `sum_out` there equals A+B. That value is never all ones.
- R6: When A+B = 2^W-1 the result is 0, in the accept cycle. When A = B = 2^W-1 the result is all ones (2^W-1), in the accept cycle.
- R7: Operands must stay unchanged from the accept cycle through the second cycle of the window.
- R8: `sum_out` and `valid_out` depend combinationally on the operands and on the phase, with no extra output register. The result is visible in the cycle in which `valid_out` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | W | First operand |
| b_in | input | W | Second operand |
| sum_out | output | W | Low W bits of the shared adder (the result when valid_out is high) |
| valid_out | output | 1 | The result on sum_out is final in this cycle |
| accept_out | output | 1 | Accept phase: carry input is 1 and a new operand pair may be presented |

## Verification
A phase register that fails to toggle makes `accept_out` stick. `valid_out` then pulses twice or not at all in a window, and this shows within two cycles of reset. A registered carry-out that is wrong or stale makes `valid_out` rise in both cycles of a window, or in neither, for operands that sum just below 2^W-1. A carry input of the wrong polarity puts an off-by-one error on `sum_out` in the very first window. Directed sums on each side of 2^W-1, both operands at the maximum, and a reset in the middle of a window are mixed with random and near-boundary operand pairs.

// File: rtl/modadd_half.sv
module modadd_half #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] sum_out,
  output logic         valid_out,
  output logic         accept_out
);
  localparam int SW = W + 1;

  logic          cin_q;
  logic          cout_q;
  logic [SW-1:0] full_sum;
  logic          cout;

  assign full_sum = {1'b0, a_in} + {1'b0, b_in} + {{W{1'b0}}, cin_q};
  assign cout     = full_sum[W];

  always_ff @(posedge clk) begin
    if (rst) begin
      cin_q  <= 1'b1;
      cout_q <= 1'b0;
    end else begin
      cin_q  <= ~cin_q;
      cout_q <= cout;
    end
  end

  assign sum_out    = full_sum[W-1:0];
  assign valid_out  = (cin_q & cout) | (~cin_q & ~cout_q);
  assign accept_out = cin_q;
endmodule

module modadd_half_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic [W-1:0] sum_out,
  input logic         valid_out,
  input logic         accept_out
);
  // R1
  reset_phase_chk: assert property (@(posedge clk) rst |=> accept_out);
  // R2
  phase_leave_chk: assert property (@(posedge clk) disable iff (rst) accept_out |=> !accept_out);
  // R2
  phase_return_chk: assert property (@(posedge clk) disable iff (rst) !accept_out |=> accept_out);
  // R3
  single_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_out && valid_out) |=> !valid_out);
  // R3
  late_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_out && !valid_out) |=> valid_out);
  // R4
  wrap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (accept_out && valid_out) |-> (sum_out <= a_in && sum_out <= b_in));
  // R5
  late_not_ones_chk: assert property (@(posedge clk) disable iff (rst)
    (!accept_out && valid_out) |-> (sum_out != {W{1'b1}}));
  // R7
  hold_a_chk: assert property (@(posedge clk) disable iff (rst) !accept_out |-> $stable(a_in));
  // R7
  hold_b_chk: assert property (@(posedge clk) disable iff (rst) !accept_out |-> $stable(b_in));
endmodule

bind modadd_half modadd_half_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
  .sum_out(sum_out), .valid_out(valid_out), .accept_out(accept_out)
);

// File: tb/modadd_half_bench.sv
`timescale 1ns/100ps
module modadd_half_bench;
  localparam int W = 32;
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] a_in = '0;
  logic [W-1:0] b_in = '0;
  logic [W-1:0] sum_out;
  logic         valid_out;
  logic         accept_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  modadd_half #(.W(W)) u_modadd_half (
    .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
    .sum_out(sum_out), .valid_out(valid_out), .accept_out(accept_out)
  );

  function automatic logic [W-1:0] ref_sum(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, MAXV}) s = s - {1'b0, MAXV};
    return s[W-1:0];
  endfunction

  function automatic bit ref_early(logic [W-1:0] a, logic [W-1:0] b);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s >= {1'b0, MAXV};
  endfunction

  task automatic check(bit ok, string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Entered at posedge+1 in an accept cycle; leaves at posedge+1 of the next accept cycle.
  task automatic run_pair(logic [W-1:0] a, logic [W-1:0] b);
    logic         v0, v1, ac0, ac1;
    logic [W-1:0] s0, s1, exp;
    bit           early;
    a_in = a;
    b_in = b;
    #1;
    v0 = valid_out; s0 = sum_out; ac0 = accept_out;
    @(posedge clk); #1;
    v1 = valid_out; s1 = sum_out; ac1 = accept_out;
    @(posedge clk); #1;
    exp   = ref_sum(a, b);
    early = ref_early(a, b);
    check(ac0 == 1'b1 && ac1 == 1'b0, "R2 accept phase", {30'd0, ac0, ac1}, 32'd2);
    check((v0 ^ v1) == 1'b1, "R3 one valid per window", {30'd0, v0, v1}, 32'd1);
    if (early) begin
      check(v0 == 1'b1, "R4 early valid", {31'd0, v0}, 32'd1);
      check(s0 == exp, "R4 wrapped sum", s0, exp);
    end else begin
      check(v1 == 1'b1, "R5 late valid", {31'd0, v1}, 32'd1);
      check(s1 == exp, "R5 plain sum", s1, exp);
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(accept_out == 1'b1, "R1 accept in reset", {31'd0, accept_out}, 32'd1);
    check(valid_out == 1'b0, "R1 no valid in reset", {31'd0, valid_out}, 32'd0);
    rst = 1'b0;
    // R1: first window after reset, small operands, valid in second cycle
    a_in = 32'd5; b_in = 32'd7;
    #1;
    check(valid_out == 1'b0, "R1 first cycle idle", {31'd0, valid_out}, 32'd0);
    @(posedge clk); #1;
    check(valid_out == 1'b1, "R1 second cycle valid", {31'd0, valid_out}, 32'd1);
    check(sum_out == 32'd12, "R8 sum visible with valid", sum_out, 32'd12);
    @(posedge clk); #1;

    // R6: boundary sums
    run_pair(32'h8000_0000, 32'h7FFF_FFFF);
    check(sum_out == 32'd0 && valid_out, "R6 sum of 2^W-1 gives 0", sum_out, 32'd0);
    a_in = 32'h8000_0000; b_in = 32'h7FFF_FFFF; #1;
    @(posedge clk); #1;
    @(posedge clk); #1;
    run_pair(MAXV, MAXV);
    a_in = MAXV; b_in = MAXV; #1;
    check(valid_out && sum_out == MAXV, "R6 max plus max", sum_out, MAXV);
    @(posedge clk); #1;
    @(posedge clk); #1;
    run_pair(32'h0000_0000, 32'h0000_0000);
    run_pair(MAXV, 32'd0);
    run_pair(MAXV, 32'd1);
    run_pair(32'hFFFF_FFFE, 32'd0);
    run_pair(32'hFFFF_FFFE, 32'd2);

    // R1: reset in the middle of a window
    a_in = 32'd3; b_in = 32'd4;
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    check(accept_out == 1'b1, "R1 reset mid window", {31'd0, accept_out}, 32'd1);
    rst = 1'b0;
    run_pair(32'd3, 32'd4);

    // R4 R5: random and near-boundary pairs
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] ra, rb;
      ra = $urandom;
      case (i % 3)
        0: rb = $urandom;
        1: rb = ~ra + ($urandom % 3) - 32'd1;
        default: rb = MAXV - ($urandom % 4);
      endcase
      run_pair(ra, rb);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule